// File: doc/BRIEF.md
# Word-Serial Hash I/O Controller

This block sits between a word-wide host interface and a hash core. It takes in a message block one 64-bit word per clock edge through a handshake that the host opens by raising `load`. The block answers with `ack` while it is able to accept data and drops `ack` by itself once a full block has been gathered. It then launches the core with a one-cycle start pulse and waits for the core's done pulse. After that it streams the digest back one word per clock edge, with `hash_valid` high for exactly as many cycles as the digest has words.

The permutation itself is not part of this block. A small multi-cycle stand-in core with a fixed latency of `CORE_LAT` cycles fills its place, so that the controller can be exercised end to end. One parameter selects a 256-bit digest (4 output words) or a 512-bit digest (8 output words). A single word counter, cleared at every phase change, indexes both the input words and the output words.

Top module: `hash_io_ctrl`

## Requirements
- R1: An active-high synchronous reset, applied at any point including mid-block, returns the block to idle with `ack` and `hash_valid` low at the next edge.
- R2: In idle, `ack` rises one cycle after a rising edge that samples `load` high, and it stays low for as long as `load` is sampled low.
- R3: On every rising edge while `ack` is high, `data_in` is captured as the next block word. The first word lands in block bits [63:0], the second in [127:64], and so on.
- R4: `ack` falls after exactly `IN_WORDS` words have been captured.
- R5: While the core computes and while the digest is being sent, `ack` stays low, and the values of `load` and `data_in` have no effect on the digest.
- R6: `hash_valid` rises `CORE_LAT`+2 edges after the edge that captured the last input word.
- R7: The digest is sent least significant word first, one word per edge. `hash_valid` stays high for exactly `DIGEST_BITS`/64 cycles: 4 for 256 bits and 8 for 512 bits.
- R8: The stand-in core computes output word j as B[j mod IN_WORDS] xor rotl8(B[(j+1) mod IN_WORDS]) xor (j+1). B is the gathered block and rotl8 is a left rotation of the 64-bit word by 8 bits.
- R9: After the last digest word the block returns to idle, and a later `load` starts a new, independent block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Host request to start an input block |
| data_in | input | WORD_W | Message word |
| ack | output | 1 | Block is accepting a word on each edge |
| hash_valid | output | 1 | data_out carries a digest word |
| data_out | output | WORD_W | Digest word |

## Verification
Two instances, one with a 256-bit digest and one with a 512-bit digest, share the same stimulus. This makes the word count of each digest and the cutoff of `hash_valid` stand out directly. Blocks of all zeros, all ones and a walking count separate errors in word placement from errors in rotation or in the index constant. Fixed-seed random blocks then cover the remaining value space. During the core wait, `load` and `data_in` carry random values, which would expose any capture outside the window in which `ack` is high. A reset in the middle of a block shows that no partial state survives into the next one.

// File: rtl/hio_pkg.sv
package hio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_WAIT   = 2'd2,
    ST_OUT    = 2'd3
  } hio_state_t;

  localparam int unsigned ROT_BITS = 8;
endpackage

// File: rtl/hio_fsm.sv
module hio_fsm
  import hio_pkg::*;
#(
  parameter int unsigned IN_WORDS  = 8,
  parameter int unsigned OUT_WORDS = 4,
  localparam int unsigned MAXW  = (IN_WORDS > OUT_WORDS) ? IN_WORDS : OUT_WORDS,
  localparam int unsigned CNT_W = $clog2(MAXW + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             core_done,
  output logic             ack,
  output logic             hash_valid,
  output logic             core_start,
  output logic [CNT_W-1:0] word_idx,
  output logic             out_load,
  output logic             out_shift
);
  hio_state_t       st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      ack        <= 1'b0;
      hash_valid <= 1'b0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (load) begin
            st  <= ST_GATHER;
            ack <= 1'b1;
            cnt <= '0;
          end
        end
        ST_GATHER: begin
          if (cnt == CNT_W'(IN_WORDS - 1)) begin
            ack        <= 1'b0;
            core_start <= 1'b1;
            st         <= ST_WAIT;
            cnt        <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (core_done) begin
            hash_valid <= 1'b1;
            st         <= ST_OUT;
            cnt        <= '0;
          end
        end
        ST_OUT: begin
          if (cnt == CNT_W'(OUT_WORDS - 1)) begin
            hash_valid <= 1'b0;
            st         <= ST_IDLE;
            cnt        <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign word_idx  = cnt;
  assign out_load  = (st == ST_WAIT) && core_done;
  assign out_shift = (st == ST_OUT);

  // R2: ack only opens after load was seen while idle
  a_r2_ack_after_load: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(load) && ($past(st) == ST_IDLE));
  // R6: start is a single-cycle pulse
  a_r6_start_pulse: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);
  // R7: valid window closes only on the last output word
  a_r7_valid_len: assert property (@(posedge clk) disable iff (rst)
    $fell(hash_valid) |-> $past(cnt) == CNT_W'(OUT_WORDS - 1));
endmodule

// File: rtl/hio_gather.sv
module hio_gather #(
  parameter int unsigned WORD_W   = 64,
  parameter int unsigned IN_WORDS = 8,
  parameter int unsigned CNT_W    = 4,
  localparam int unsigned BLK_W   = WORD_W * IN_WORDS
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [BLK_W-1:0]  blk
);
  for (genvar i = 0; i < IN_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == CNT_W'(i)))
        blk[i*WORD_W +: WORD_W] <= wr_data;
    end
  end
endmodule

// File: rtl/hio_stub_core.sv
module hio_stub_core
  import hio_pkg::*;
#(
  parameter int unsigned WORD_W    = 64,
  parameter int unsigned IN_WORDS  = 8,
  parameter int unsigned OUT_WORDS = 4,
  parameter int unsigned CORE_LAT  = 3,
  localparam int unsigned BLK_W = WORD_W * IN_WORDS,
  localparam int unsigned DIG_W = WORD_W * OUT_WORDS,
  localparam int unsigned LAT_W = $clog2(CORE_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] blk,
  output logic             done,
  output logic [DIG_W-1:0] digest
);
  logic [DIG_W-1:0] mix;
  logic             busy;
  logic [LAT_W-1:0] lat_cnt;

  for (genvar j = 0; j < OUT_WORDS; j++) begin : g_mix
    localparam int unsigned A = j % IN_WORDS;
    localparam int unsigned B = (j + 1) % IN_WORDS;
    logic [WORD_W-1:0] wa, wb;
    assign wa = blk[A*WORD_W +: WORD_W];
    assign wb = blk[B*WORD_W +: WORD_W];
    assign mix[j*WORD_W +: WORD_W] =
      wa ^ {wb[WORD_W-ROT_BITS-1:0], wb[WORD_W-1 -: ROT_BITS]} ^ WORD_W'(j + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      lat_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        lat_cnt <= '0;
      end else if (busy) begin
        if (lat_cnt == LAT_W'(CORE_LAT - 1)) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          digest <= mix;
        end else begin
          lat_cnt <= lat_cnt + 1'b1;
        end
      end
    end
  end

  // R6: the core is never restarted while still computing
  a_r6_start_when_free: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/hio_unload.sv
module hio_unload #(
  parameter int unsigned WORD_W    = 64,
  parameter int unsigned OUT_WORDS = 4,
  localparam int unsigned DIG_W    = WORD_W * OUT_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic              shift,
  input  logic [DIG_W-1:0]  din,
  output logic [WORD_W-1:0] dout
);
  logic [DIG_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst)        sreg <= '0;
    else if (ld)    sreg <= din;
    else if (shift) sreg <= DIG_W'(sreg >> WORD_W);
  end

  assign dout = sreg[WORD_W-1:0];
endmodule

// File: rtl/hash_io_ctrl.sv
module hash_io_ctrl #(
  parameter int unsigned WORD_W      = 64,
  parameter int unsigned IN_WORDS    = 8,
  parameter int unsigned DIGEST_BITS = 256,
  parameter int unsigned CORE_LAT    = 3,
  localparam int unsigned OUT_WORDS  = DIGEST_BITS / WORD_W,
  localparam int unsigned BLK_W      = WORD_W * IN_WORDS,
  localparam int unsigned DIG_W      = WORD_W * OUT_WORDS,
  localparam int unsigned MAXW       = (IN_WORDS > OUT_WORDS) ? IN_WORDS : OUT_WORDS,
  localparam int unsigned CNT_W      = $clog2(MAXW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] data_in,
  output logic              ack,
  output logic              hash_valid,
  output logic [WORD_W-1:0] data_out
);
  logic             core_start, core_done, out_load, out_shift;
  logic [CNT_W-1:0] word_idx;
  logic [BLK_W-1:0] blk;
  logic [DIG_W-1:0] digest;

  hio_fsm #(.IN_WORDS(IN_WORDS), .OUT_WORDS(OUT_WORDS)) u_fsm (
    .clk(clk), .rst(rst), .load(load), .core_done(core_done),
    .ack(ack), .hash_valid(hash_valid), .core_start(core_start),
    .word_idx(word_idx), .out_load(out_load), .out_shift(out_shift));

  hio_gather #(.WORD_W(WORD_W), .IN_WORDS(IN_WORDS), .CNT_W(CNT_W)) u_gather (
    .clk(clk), .wr_en(ack), .wr_idx(word_idx), .wr_data(data_in), .blk(blk));

  hio_stub_core #(.WORD_W(WORD_W), .IN_WORDS(IN_WORDS), .OUT_WORDS(OUT_WORDS),
                  .CORE_LAT(CORE_LAT)) u_core (
    .clk(clk), .rst(rst), .start(core_start), .blk(blk),
    .done(core_done), .digest(digest));

  hio_unload #(.WORD_W(WORD_W), .OUT_WORDS(OUT_WORDS)) u_unload (
    .clk(clk), .rst(rst), .ld(out_load), .shift(out_shift),
    .din(digest), .dout(data_out));

  // R5: input and output phases never overlap
  a_r5_no_ack_in_output: assert property (@(posedge clk) disable iff (rst)
    hash_valid |-> !ack);
  // R1: reset leaves both handshake outputs low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !ack && !hash_valid);
endmodule

// File: tb/hash_io_ctrl_tb_top.sv
`timescale 1ns/1ps
module hash_io_ctrl_tb_top;
  localparam int N   = 5;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [63:0] data_in = '0;
  logic        ack_a, val_a, ack_b, val_b;
  logic [63:0] dout_a, dout_b;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] w [N];

  always #2.5 clk = ~clk;

  hash_io_ctrl #(.WORD_W(64), .IN_WORDS(N), .DIGEST_BITS(256), .CORE_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .load(load), .data_in(data_in),
    .ack(ack_a), .hash_valid(val_a), .data_out(dout_a));

  hash_io_ctrl #(.WORD_W(64), .IN_WORDS(N), .DIGEST_BITS(512), .CORE_LAT(LAT)) dut512_i (
    .clk(clk), .rst(rst), .load(load), .data_in(data_in),
    .ack(ack_b), .hash_valid(val_b), .data_out(dout_b));

  function automatic logic [63:0] rotl8(logic [63:0] x);
    return {x[55:0], x[63:56]};
  endfunction

  function automatic logic [63:0] exp_word(int j);
    return w[j % N] ^ rotl8(w[(j + 1) % N]) ^ 64'(j + 1);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_block();
    int lat;
    @(negedge clk);
    load = 1'b1;
    data_in = {$urandom, $urandom};
    @(posedge clk); @(negedge clk);
    chk("R2 ack rise", {62'd0, ack_a, ack_b}, 64'd3);
    for (int i = 0; i < N; i++) begin
      data_in = w[i];
      chk("R3 ack during gather", {62'd0, ack_a, ack_b}, 64'd3);
      @(posedge clk); @(negedge clk);
    end
    chk("R4 ack fall", {62'd0, ack_a, ack_b}, 64'd0);
    load = 1'b0;
    lat = 0;
    while (!val_a && lat < 50) begin
      load = 1'($urandom);
      data_in = {$urandom, $urandom};
      chk("R5 ack low in wait", {62'd0, ack_a, ack_b}, 64'd0);
      @(posedge clk); @(negedge clk);
      lat++;
    end
    load = 1'b0;
    chk("R6 latency", 64'(lat), 64'(LAT + 2));
    for (int k = 0; k < 8; k++) begin
      chk("R7 valid 256", {63'd0, val_a}, {63'd0, (k < 4)});
      chk("R7 valid 512", {63'd0, val_b}, 64'd1);
      if (k < 4) chk("R8 word 256", dout_a, exp_word(k));
      chk("R8 word 512", dout_b, exp_word(k));
      chk("R5 ack low in output", {62'd0, ack_a, ack_b}, 64'd0);
      @(posedge clk); @(negedge clk);
    end
    chk("R9 back to idle", {60'd0, ack_a, ack_b, val_a, val_b}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {60'd0, ack_a, ack_b, val_a, val_b}, 64'd0);
    rst = 1'b0;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk("R2 idle without load", {62'd0, ack_a, ack_b}, 64'd0);
    end
    // directed: zeros, ones, walking count
    for (int i = 0; i < N; i++) w[i] = '0;
    run_block();
    for (int i = 0; i < N; i++) w[i] = '1;
    run_block();
    for (int i = 0; i < N; i++) w[i] = 64'(i + 1) << (8 * i);
    run_block();
    // reset in the middle of a block
    @(negedge clk);
    load = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); data_in = {$urandom, $urandom}; end
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 mid-block reset", {60'd0, ack_a, ack_b, val_a, val_b}, 64'd0);
    rst = 1'b0;
    load = 1'b0;
    repeat (2) begin
      @(posedge clk); @(negedge clk);
      chk("R2 no ack after reset", {62'd0, ack_a, ack_b}, 64'd0);
    end
    // random blocks, R9 repeated independent transactions
    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < N; i++) w[i] = {$urandom, $urandom};
      run_block();
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule